// File: doc/BRIEF.md
# Two-Stage Deflection Arbitration Network

This block is the routing core of a four-port mesh router that has no input buffering. Every cycle up to four flits arrive, one per input link (North, East, South, West). Every one of them must leave on exactly one of the four output links in the following cycle, because nothing can be held back. The block is built from two stages of 2x2 arbiter-steering cells. Each cell compares its two flits, steers the winner toward the half (stage one) or the port (stage two) it wants, and pushes the loser the other way. A flit that ends up on a port other than the one it asked for is flagged as deflected.

Each cell decides alone using three priority levels. A golden flit beats any other flit, and among golden flits the lower sequence number wins. Failing that, a silver flit beats a plain flit. Failing both, a free-running LFSR bit private to the cell picks the winner. A flit at the top of this order wins every cell it meets, so it always reaches its requested port. In particular, a single silver flit guarantees that one flit per cycle is not deflected, even though the cells never coordinate.

Route computation happens outside the block; each flit simply carries its requested port. All outputs are registered, so results appear one clock after the inputs.

Top module: `dfl_arbnet`

## Requirements
- R1: Every valid input flit appears on exactly one output port one clock later, with its destination, golden, silver, sequence and data fields unchanged. The number of valid outputs equals the number of valid inputs, and invalid input slots produce no valid output.
- R2: While `rst` is high (synchronous), every output valid bit and every deflected bit is 0 from the next clock edge on.
- R3: Port numbering is 0 = North, 1 = East, 2 = South, 3 = West, and the 2-bit destination field uses the same code. `out_defl[p]` is 1 exactly when port p carries a valid flit whose destination is not p.
- R4: Among the valid golden inputs of a cycle, the one with the lowest sequence number is never deflected.
- R5: When no valid input is golden and one valid input is silver, that silver flit is never deflected.
- R6: A golden flit outranks a silver flit. If the two contend in a cell for the same side, the golden flit takes its requested port and the silver flit is deflected.
- R7: A flit that is the only valid input of its cycle always leaves on its requested port, and is not flagged deflected.
- R8: When two flits with neither golden nor silver set contend for the same side, the choice comes from a per-cell LFSR that never holds zero. Over repeated identical contests, each flit wins at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Valid bit per input link (bit i = link i) |
| in_dest | input | 8 | Requested output port per input, 2 bits each |
| in_golden | input | 4 | Golden flag per input |
| in_silver | input | 4 | Silver flag per input (at most one set per cycle) |
| in_seq | input | 4*SEQ_W | Sequence number per input |
| in_data | input | 4*DATA_W | Payload per input |
| out_valid | output | 4 | Valid bit per output port |
| out_dest | output | 8 | Requested port of the flit on each output |
| out_golden | output | 4 | Golden flag of the flit on each output |
| out_silver | output | 4 | Silver flag of the flit on each output |
| out_seq | output | 4*SEQ_W | Sequence number of the flit on each output |
| out_data | output | 4*DATA_W | Payload of the flit on each output |
| out_defl | output | 4 | Flit on this port is not on its requested port |

## Verification
A wrong cell decision or a miswired stage shows up in the very next cycle, as either a lost or duplicated payload across the output ports or a top-priority flit on the wrong port. The bench tags every payload with its vector number and input index, so each output can be traced back to exactly one input. A stuck or zeroed LFSR cannot be seen in any single cycle. It appears over a run of identical plain contests as one contender that never wins, and the bench measures this with an explicit count.

// File: rtl/dfl_pkg.sv
`timescale 1ns/1ps
package dfl_pkg;

  localparam int NUM_PORTS = 4;
  localparam int DEST_W    = 2;

  typedef enum logic [DEST_W-1:0] {
    PORT_NORTH = 2'd0,
    PORT_EAST  = 2'd1,
    PORT_SOUTH = 2'd2,
    PORT_WEST  = 2'd3
  } port_e;

  // Three-level cell priority: golden (lower sequence first), silver, then coin.
  // Returns 1 when slot A wins the cell.
  function automatic logic pick_a(input logic a_vld, input logic a_gold,
                                  input logic a_sil, input logic b_vld,
                                  input logic b_gold, input logic b_sil,
                                  input logic a_seq_lower, input logic seq_same,
                                  input logic coin);
    if (!b_vld)            return 1'b1;
    if (!a_vld)            return 1'b0;
    if (a_gold != b_gold)  return a_gold;
    if (a_gold)            return seq_same ? coin : a_seq_lower;
    if (a_sil != b_sil)    return a_sil;
    return coin;
  endfunction

endpackage

// File: rtl/dfl_lfsr.sv
`timescale 1ns/1ps
module dfl_lfsr #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    TAPS = 8'hB8,
  parameter logic [W-1:0]    SEED = 8'h5A
) (
  input  logic clk,
  input  logic rst,
  output logic coin
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_d;
  end

  assign coin = state_q[0];

  // R8: the coin source never locks up in the all-zero state
  p_state_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/dfl_cell.sv
`timescale 1ns/1ps
module dfl_cell
  import dfl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEQ_W     = 4,
  parameter int STEER_BIT = 1,
  localparam int FLIT_W   = 1 + DEST_W + 1 + 1 + SEQ_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coin,
  input  logic [FLIT_W-1:0] in_a,
  input  logic [FLIT_W-1:0] in_b,
  output logic [FLIT_W-1:0] out_lo,
  output logic [FLIT_W-1:0] out_hi
);

  typedef struct packed {
    logic              vld;
    logic [DEST_W-1:0] dest;
    logic              gold;
    logic              silv;
    logic [SEQ_W-1:0]  seq;
    logic [DATA_W-1:0] data;
  } flit_t;

  flit_t fa, fb, win, lose;
  logic  a_wins;
  logic  win_side;

  assign fa = flit_t'(in_a);
  assign fb = flit_t'(in_b);

  always_comb begin
    a_wins = pick_a(fa.vld, fa.gold, fa.silv, fb.vld, fb.gold, fb.silv,
                    fa.seq < fb.seq, fa.seq == fb.seq, coin);
    win      = a_wins ? fa : fb;
    lose     = a_wins ? fb : fa;
    win_side = win.dest[STEER_BIT];
    out_hi   = win_side ? win  : lose;
    out_lo   = win_side ? lose : win;
  end

  // R1: a cell neither drops nor creates flits
  p_count_kept_r1: assert property (@(posedge clk) disable iff (rst)
    $countones({fa.vld, fb.vld}) == $countones({out_lo[FLIT_W-1], out_hi[FLIT_W-1]}));

  // R4: an unbeaten golden flit in slot A gets its requested side
  p_golden_steer_r4: assert property (@(posedge clk) disable iff (rst)
    (fa.vld && fa.gold && !(fb.vld && fb.gold && fb.seq <= fa.seq))
    |-> ((fa.dest[STEER_BIT] ? out_hi : out_lo) == in_a));

  // R5: a silver flit facing no golden or silver rival gets its requested side
  p_silver_steer_r5: assert property (@(posedge clk) disable iff (rst)
    (fb.vld && fb.silv && !(fa.vld && (fa.gold || fa.silv)))
    |-> ((fb.dest[STEER_BIT] ? out_hi : out_lo) == in_b));

endmodule

// File: rtl/dfl_arbnet.sv
`timescale 1ns/1ps
module dfl_arbnet
  import dfl_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              SEQ_W     = 4,
  parameter int              LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          in_valid,
  input  logic [NUM_PORTS*DEST_W-1:0]   in_dest,
  input  logic [NUM_PORTS-1:0]          in_golden,
  input  logic [NUM_PORTS-1:0]          in_silver,
  input  logic [NUM_PORTS*SEQ_W-1:0]    in_seq,
  input  logic [NUM_PORTS*DATA_W-1:0]   in_data,
  output logic [NUM_PORTS-1:0]          out_valid,
  output logic [NUM_PORTS*DEST_W-1:0]   out_dest,
  output logic [NUM_PORTS-1:0]          out_golden,
  output logic [NUM_PORTS-1:0]          out_silver,
  output logic [NUM_PORTS*SEQ_W-1:0]    out_seq,
  output logic [NUM_PORTS*DATA_W-1:0]   out_data,
  output logic [NUM_PORTS-1:0]          out_defl
);

  localparam int FLIT_W    = 1 + DEST_W + 1 + 1 + SEQ_W + DATA_W;
  localparam int HALF      = NUM_PORTS / 2;
  localparam int NUM_CELLS = 2 * HALF;

  typedef struct packed {
    logic              vld;
    logic [DEST_W-1:0] dest;
    logic              gold;
    logic              silv;
    logic [SEQ_W-1:0]  seq;
    logic [DATA_W-1:0] data;
  } flit_t;

  logic [FLIT_W-1:0] in_w   [NUM_PORTS];
  logic [FLIT_W-1:0] mid_w  [2][HALF];
  logic [FLIT_W-1:0] net_w  [NUM_PORTS];
  logic              coin_w [NUM_CELLS];
  logic              hist_ok_q;

  // Per-cell coin sources, each with its own seed
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_coin
    dfl_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED ^ LFSR_W'(32'(c) * 32'h31))
    ) u_lfsr (
      .clk  (clk),
      .rst  (rst),
      .coin (coin_w[c])
    );
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pack
    assign in_w[i] = {in_valid[i], in_dest[DEST_W*i +: DEST_W], in_golden[i],
                      in_silver[i], in_seq[SEQ_W*i +: SEQ_W], in_data[DATA_W*i +: DATA_W]};
  end

  // Stage one: inputs j and j+HALF meet; steering on the upper destination bit
  for (genvar j = 0; j < HALF; j++) begin : g_st1
    dfl_cell #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .STEER_BIT(1)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .coin   (coin_w[j]),
      .in_a   (in_w[j]),
      .in_b   (in_w[j+HALF]),
      .out_lo (mid_w[0][j]),
      .out_hi (mid_w[1][j])
    );
  end

  // Stage two: cell k owns output ports 2k and 2k+1; steering on the lower bit
  for (genvar k = 0; k < HALF; k++) begin : g_st2
    dfl_cell #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .STEER_BIT(0)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .coin   (coin_w[HALF+k]),
      .in_a   (mid_w[k][0]),
      .in_b   (mid_w[k][1]),
      .out_lo (net_w[2*k]),
      .out_hi (net_w[2*k+1])
    );
  end

  // Output registers
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    flit_t f;
    assign f = flit_t'(net_w[p]);
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[p]                    <= 1'b0;
        out_defl[p]                     <= 1'b0;
        out_dest[DEST_W*p +: DEST_W]    <= '0;
        out_golden[p]                   <= 1'b0;
        out_silver[p]                   <= 1'b0;
        out_seq[SEQ_W*p +: SEQ_W]       <= '0;
        out_data[DATA_W*p +: DATA_W]    <= '0;
      end else begin
        out_valid[p]                    <= f.vld;
        out_defl[p]                     <= f.vld && (f.dest != DEST_W'(p));
        out_dest[DEST_W*p +: DEST_W]    <= f.dest;
        out_golden[p]                   <= f.gold;
        out_silver[p]                   <= f.silv;
        out_seq[SEQ_W*p +: SEQ_W]       <= f.seq;
        out_data[DATA_W*p +: DATA_W]    <= f.data;
      end
    end
  end

  // Marks that the previous cycle was out of reset, so $past inputs are meaningful
  always_ff @(posedge clk) begin
    if (rst) hist_ok_q <= 1'b0;
    else     hist_ok_q <= 1'b1;
  end

  // R2: reset empties every output port
  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && out_defl == '0));

  // R1: flit count is preserved across the one-cycle latency
  p_count_latency_r1: assert property (@(posedge clk) disable iff (rst)
    hist_ok_q |-> ($countones(out_valid) == $past($countones(in_valid))));

  // R4: some golden flit leaves undeflected whenever golden flits entered
  p_golden_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (hist_ok_q && $past(|(in_valid & in_golden)))
    |-> (|(out_valid & out_golden & ~out_defl)));

  // R5: with no golden traffic, the silver flit leaves undeflected
  p_silver_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_ok_q && $past(|(in_valid & in_silver)) && $past((in_valid & in_golden) == '0))
    |-> (|(out_valid & out_silver & ~out_defl)));

endmodule

// File: tb/dfl_arbnet_test.sv
`timescale 1ns/1ps
module dfl_arbnet_test;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    in_valid, in_golden, in_silver;
  logic [2*NP-1:0]  in_dest;
  logic [SW*NP-1:0] in_seq;
  logic [DW*NP-1:0] in_data;
  logic [NP-1:0]    out_valid, out_golden, out_silver, out_defl;
  logic [2*NP-1:0]  out_dest;
  logic [SW*NP-1:0] out_seq;
  logic [DW*NP-1:0] out_data;

  always #5 clk = ~clk;

  dfl_arbnet #(.DATA_W(DW), .SEQ_W(SW)) uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_dest(in_dest), .in_golden(in_golden),
    .in_silver(in_silver), .in_seq(in_seq), .in_data(in_data),
    .out_valid(out_valid), .out_dest(out_dest), .out_golden(out_golden),
    .out_silver(out_silver), .out_seq(out_seq), .out_data(out_data),
    .out_defl(out_defl)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic          v [NP];
  logic          g [NP];
  logic          s [NP];
  logic [1:0]    d [NP];
  logic [SW-1:0] q [NP];
  logic [DW-1:0] dat [NP];
  logic [13:0]   vid = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < NP; i++) begin
      v[i] = 1'b0; g[i] = 1'b0; s[i] = 1'b0; d[i] = 2'd0; q[i] = '0;
    end
  endtask

  task automatic put(input int i, input int dst, input bit gold, input bit sil,
                     input int seq);
    v[i] = 1'b1; d[i] = 2'(dst); g[i] = gold; s[i] = sil; q[i] = SW'(seq);
  endtask

  task automatic drive();
    for (int i = 0; i < NP; i++) begin
      dat[i]                = {vid, 2'(i)};
      in_valid[i]           = v[i];
      in_golden[i]          = g[i];
      in_silver[i]          = s[i];
      in_dest[2*i +: 2]     = d[i];
      in_seq[SW*i +: SW]    = q[i];
      in_data[DW*i +: DW]   = dat[i];
    end
  endtask

  // Drive at a falling edge, result is registered at the next rising edge
  task automatic step();
    drive();
    @(posedge clk);
    @(negedge clk);
    vid = vid + 14'd1;
  endtask

  function automatic int port_of(input int i);
    for (int p = 0; p < NP; p++)
      if (out_valid[p] && out_data[DW*p +: DW] == dat[i]) return p;
    return -1;
  endfunction

  task automatic verify_general();
    int  nin = 0;
    bit  ok1 = 1'b1;
    logic [NP-1:0] exp_defl;
    int  best = -1;
    int  sil = -1;
    for (int i = 0; i < NP; i++) begin
      if (v[i]) begin
        int hits = 0;
        nin++;
        for (int p = 0; p < NP; p++) begin
          if (out_valid[p] && out_data[DW*p +: DW] == dat[i]) begin
            hits++;
            if (out_dest[2*p +: 2] != d[i] || out_golden[p] != g[i] ||
                out_silver[p] != s[i] || out_seq[SW*p +: SW] != q[i]) ok1 = 1'b0;
          end
        end
        if (hits != 1) ok1 = 1'b0;
      end
    end
    if ($countones(out_valid) != nin) ok1 = 1'b0;
    check(ok1, "R1", "valid output count", $countones(out_valid), nin);
    for (int p = 0; p < NP; p++)
      exp_defl[p] = out_valid[p] && (out_dest[2*p +: 2] != 2'(p));
    check(out_defl == exp_defl, "R3", "deflect flags", out_defl, exp_defl);
    for (int i = 0; i < NP; i++) begin
      if (v[i] && g[i] && (best < 0 || q[i] < q[best])) best = i;
      if (v[i] && s[i]) sil = i;
    end
    if (best >= 0)
      check(port_of(best) == int'(d[best]), "R4", "lowest golden port",
            port_of(best), d[best]);
    else if (sil >= 0)
      check(port_of(sil) == int'(d[sil]), "R5", "silver port",
            port_of(sil), d[sil]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0 = 0;
    int c2 = 0;
    // R2: full traffic offered while reset is held
    clear_all();
    for (int i = 0; i < NP; i++) put(i, 3 - i, 1'b0, i == 0, 0);
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == '0, "R2", "valid during reset", out_valid, 0);
    check(out_defl == '0, "R2", "deflect during reset", out_defl, 0);
    rst = 1'b0;

    // R7: each lone flit to each port
    for (int i = 0; i < NP; i++) begin
      for (int dst = 0; dst < NP; dst++) begin
        clear_all();
        put(i, dst, 1'b0, 1'b0, 0);
        step();
        check(port_of(i) == dst && out_defl == '0 && $countones(out_valid) == 1,
              "R7", "lone flit port", port_of(i), dst);
      end
    end

    // R6: golden vs silver for the same port, both slot orders
    clear_all();
    put(0, 0, 1'b1, 1'b0, 5);
    put(1, 0, 1'b0, 1'b1, 0);
    step();
    check(port_of(0) == 0 && out_defl[0] == 1'b0, "R6", "golden port", port_of(0), 0);
    check(port_of(1) == 1 && out_defl[1] == 1'b1, "R6", "silver port", port_of(1), 1);
    clear_all();
    put(0, 0, 1'b0, 1'b1, 0);
    put(1, 0, 1'b1, 1'b0, 2);
    step();
    check(port_of(1) == 0 && out_defl[0] == 1'b0, "R6", "golden port swapped", port_of(1), 0);
    check(port_of(0) == 1 && out_defl[1] == 1'b1, "R6", "silver port swapped", port_of(0), 1);

    // R8: repeated plain contest for port 0 between inputs 0 and 2
    for (int n = 0; n < 64; n++) begin
      clear_all();
      put(0, 0, 1'b0, 1'b0, 0);
      put(2, 0, 1'b0, 1'b0, 0);
      step();
      if (port_of(0) == 0) c0++;
      if (port_of(2) == 0) c2++;
    end
    check(c0 > 0 && c2 > 0 && c0 + c2 == 64, "R8", "wins of input 0", c0, 1);

    // Sweep: all destination patterns, all valid masks, six flag modes
    for (int dd = 0; dd < 256; dd++) begin
      for (int vm = 0; vm < 16; vm++) begin
        for (int mode = 0; mode < 6; mode++) begin
          clear_all();
          for (int i = 0; i < NP; i++) begin
            v[i] = vm[i];
            d[i] = 2'(dd >> (2*i));
            q[i] = SW'((i + dd) % 4);
            if (mode == 5) begin
              g[i] = 1'((dd >> i) ^ (dd >> (i + 4)));
              s[i] = (i == (dd & 3));
            end else begin
              s[i] = (mode >= 1 && i == mode - 1);
            end
          end
          step();
          verify_general();
        end
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule